// File: doc/BRIEF.md
# External Memory Strobe Controller

This block runs single-word read and write cycles on an off-chip parallel bus that serves several memory spaces. Each space has its own timing and format register. The register sets the read and write wait counts, the acknowledge-based completion, a clock divide ratio, an extra write hold period, the strobe polarity, and whether the bus is 8 or 16 bits wide. When the core issues a request, it names the space, gives a byte address, a direction and a 16-bit word. The controller snapshots the register of that space, drives the bus pins until the access completes, and then returns a one-cycle done pulse together with the read word.

On an 8-bit space a word transfer becomes two byte cycles at consecutive byte addresses. The two cycles run back to back. Arbitration between requesters, clock generation and address-to-space decoding all happen outside this block.

Top module: `ext_strobe_ctrl`

## Requirements
- R1: After reset every space register is zero. That value means an 8-bit bus, zero wait counts, divide by one, no acknowledge, no hold and active-low strobes. Also after reset, busRd and busWr are 1, busSel is 0, busDataOe is 0, busy is 0 and doneValid is 0.
- R2: A read with read wait field N (bits 3:0) holds busRd active for (N+1) divided cycles.
- R3: A write with write wait field M (bits 7:4) holds busWr active for (M+1) divided cycles. busWdata carries the word while busDataOe is 1.
- R4: A divide field D (bits 10:9) makes each divided cycle last D+1 clock cycles, so strobe widths scale by D+1.
- R5: With the acknowledge bit (bit 8) set, the strobe stays active after the count expires until busAck is sampled high on a divided-cycle boundary. With the bit clear, busAck has no effect.
- R6: With the hold bit (bit 11) set, a write keeps busAddr, busWdata and busSel driven for one divided cycle after busWr goes inactive. This happens after each byte strobe on an 8-bit space. Reads never get the hold cycle.
- R7: With the polarity bit (bit 12) set, strobes are active-high. Between accesses the strobe pins rest at the inactive level of the most recently used space.
- R8: With the width bit (bit 13) clear, a word access runs two strobe phases back to back: byte address A with the low byte first, then A+1 with the high byte. Write bytes appear on busWdata[7:0], and read bytes are taken from busRdData[7:0]. doneValid follows only the second phase.
- R9: With the width bit set, a word access runs one strobe phase on the full 16-bit data bus.
- R10: During an access exactly one busSel bit is high: the bit whose index equals the requested space ID.
- R11: doneValid is a single-cycle pulse in the cycle after the last strobe or hold cycle ends. doneRdata holds the read word in that cycle. busy is high from the cycle after acceptance until done, and a request raised while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Write strobe for a space register |
| cfgSpace | input | SP_W | Space whose register is written |
| cfgData | input | 14 | New register value |
| reqValid | input | 1 | Access request, taken when idle |
| reqSpace | input | SP_W | Space ID of the request |
| reqAddr | input | ADDR_W | Byte address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | 16 | Write word |
| busy | output | 1 | Access in progress |
| doneValid | output | 1 | One-cycle completion pulse |
| doneRdata | output | 16 | Read word, valid with doneValid |
| busAddr | output | ADDR_W | External address |
| busSel | output | NUM_SPACES | Active-high space selects |
| busRd | output | 1 | Read strobe, polarity per space |
| busWr | output | 1 | Write strobe, polarity per space |
| busWdata | output | 16 | Outgoing data |
| busDataOe | output | 1 | Data output enable |
| busRdData | input | 16 | Incoming data |
| busAck | input | 1 | External completion acknowledge |

## Verification
The bench drives strobe widths at both wait counts and divide ratios, so an off-by-one in either counter would lengthen or shorten the pulse by a whole divided cycle. On 8-bit spaces the bench checks the byte order and address increment, and it also catches a done that comes early after the first byte. Those faults would show up as swapped bytes or an unchanged address. The acknowledge tests raise busAck both late and at once. A controller that ignored it would end too early, and one that waited on it in count-only mode would hang. The hold test checks that the hold cycle appears on writes and stays absent on reads. The polarity test checks the resting pin level after an active-high access.

// File: rtl/esc_pkg.sv
`timescale 1ns/1ps
package esc_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int WAIT_W = 4;
  localparam int DIV_W  = 2;

  // Per-space register layout; bit positions are visible to software.
  typedef struct packed {
    logic              busWide;  // 13
    logic              polHigh;  // 12
    logic              holdExt;  // 11
    logic [DIV_W-1:0]  clkDiv;   // 10:9
    logic              ackMode;  // 8
    logic [WAIT_W-1:0] wrWait;   // 7:4
    logic [WAIT_W-1:0] rdWait;   // 3:0
  } spaceCfg_t;

  localparam int CFG_W = $bits(spaceCfg_t);

  typedef enum logic [1:0] {ST_IDLE, ST_STROBE, ST_HOLD} escState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;
    logic selOn;
    logic rdOn;
    logic wrOn;
    logic drvData;
    logic byteHi;
    logic capture;
    logic done;
  } dpCmd_t;
endpackage

// File: rtl/esc_cfg_bank.sv
`timescale 1ns/1ps
module esc_cfg_bank
  import esc_pkg::*;
#(
  parameter int NUM_SPACES = 4,
  parameter int SP_W       = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWe,
  input  logic [SP_W-1:0] cfgSpace,
  input  spaceCfg_t       cfgData,
  input  logic [SP_W-1:0] rdSpace,
  output spaceCfg_t       rdCfg
);
  spaceCfg_t bank [NUM_SPACES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SPACES; i++) bank[i] <= '0;
    end else if (cfgWe) begin
      bank[cfgSpace] <= cfgData;
    end
  end

  assign rdCfg = bank[rdSpace];
endmodule

// File: rtl/esc_ctrl.sv
`timescale 1ns/1ps
module esc_ctrl
  import esc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqWrite,
  input  spaceCfg_t reqCfg,
  input  logic      busAck,
  output dpCmd_t    cmd,
  output logic      busy,
  output logic      polHigh,
  output logic      busWide
);
  escState_t         state;
  spaceCfg_t         cfgQ;
  logic              isWrite, byteHi;
  logic [WAIT_W-1:0] waitCnt;
  logic [DIV_W-1:0]  divCnt;

  logic accept, tick, countDone, ackOk, useHold, strobeEnd, finishPhase, needSecond;

  always_comb begin
    accept      = (state == ST_IDLE) && reqValid;
    tick        = (divCnt == cfgQ.clkDiv);
    countDone   = (waitCnt == (isWrite ? cfgQ.wrWait : cfgQ.rdWait));
    ackOk       = !cfgQ.ackMode || busAck;
    useHold     = isWrite && cfgQ.holdExt;
    strobeEnd   = (state == ST_STROBE) && tick && countDone && ackOk;
    finishPhase = (strobeEnd && !useHold) || ((state == ST_HOLD) && tick);
    needSecond  = !cfgQ.busWide && !byteHi;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cfgQ    <= '0;
      isWrite <= 1'b0;
      byteHi  <= 1'b0;
      waitCnt <= '0;
      divCnt  <= '0;
    end else begin
      if (accept)                divCnt <= '0;
      else if (state != ST_IDLE) divCnt <= tick ? '0 : DIV_W'(divCnt + 1'b1);

      unique case (state)
        ST_IDLE: if (reqValid) begin
          state   <= ST_STROBE;
          cfgQ    <= reqCfg;
          isWrite <= reqWrite;
          byteHi  <= 1'b0;
          waitCnt <= '0;
        end
        ST_STROBE: if (tick && !countDone) waitCnt <= WAIT_W'(waitCnt + 1'b1);
                   else if (strobeEnd && useHold) state <= ST_HOLD;
        default: ;
      endcase

      if (finishPhase) begin
        if (needSecond) begin
          state   <= ST_STROBE;
          byteHi  <= 1'b1;
          waitCnt <= '0;
        end else begin
          state <= ST_IDLE;
        end
      end
    end
  end

  always_comb begin
    cmd.load    = accept;
    cmd.selOn   = (state != ST_IDLE);
    cmd.rdOn    = (state == ST_STROBE) && !isWrite;
    cmd.wrOn    = (state == ST_STROBE) && isWrite;
    cmd.drvData = (state != ST_IDLE) && isWrite;
    cmd.byteHi  = byteHi;
    cmd.capture = strobeEnd && !isWrite;
    cmd.done    = finishPhase && !needSecond;
  end

  assign busy    = (state != ST_IDLE);
  assign polHigh = cfgQ.polHigh;
  assign busWide = cfgQ.busWide;

  // R5
  ack_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STROBE && cfgQ.ackMode && !busAck) |=> (state == ST_STROBE));

  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && reqValid) |=> ($stable(cfgQ) && $stable(isWrite)));
endmodule

// File: rtl/esc_datapath.sv
`timescale 1ns/1ps
module esc_datapath
  import esc_pkg::*;
#(
  parameter int NUM_SPACES = 4,
  parameter int ADDR_W     = 16,
  parameter int SP_W       = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpCmd_t                cmd,
  input  logic                  polHigh,
  input  logic                  busWide,
  input  logic [SP_W-1:0]       reqSpace,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [WORD_W-1:0]     reqWdata,
  input  logic [WORD_W-1:0]     busRdData,
  output logic [ADDR_W-1:0]     busAddr,
  output logic [NUM_SPACES-1:0] busSel,
  output logic                  busRd,
  output logic                  busWr,
  output logic [WORD_W-1:0]     busWdata,
  output logic                  busDataOe,
  output logic                  doneValid,
  output logic [WORD_W-1:0]     doneRdata
);
  logic [ADDR_W-1:0] addrQ;
  logic [SP_W-1:0]   spaceQ;
  logic [WORD_W-1:0] wdataQ, rdataQ;
  logic [BYTE_W-1:0] byteOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ     <= '0;
      spaceQ    <= '0;
      wdataQ    <= '0;
      rdataQ    <= '0;
      doneValid <= 1'b0;
    end else begin
      doneValid <= cmd.done;
      if (cmd.load) begin
        addrQ  <= reqAddr;
        spaceQ <= reqSpace;
        wdataQ <= reqWdata;
        rdataQ <= '0;
      end else if (cmd.capture) begin
        if (busWide)         rdataQ <= busRdData;
        else if (cmd.byteHi) rdataQ[WORD_W-1:BYTE_W] <= busRdData[BYTE_W-1:0];
        else                 rdataQ[BYTE_W-1:0] <= busRdData[BYTE_W-1:0];
      end
    end
  end

  for (genvar i = 0; i < NUM_SPACES; i++) begin : g_sel
    assign busSel[i] = cmd.selOn && (spaceQ == SP_W'(i));
  end

  assign byteOut   = cmd.byteHi ? wdataQ[WORD_W-1:BYTE_W] : wdataQ[BYTE_W-1:0];
  assign busAddr   = cmd.selOn ? ADDR_W'(addrQ + ADDR_W'(cmd.byteHi)) : '0;
  assign busWdata  = !cmd.drvData ? '0 : (busWide ? wdataQ : {{(WORD_W-BYTE_W){1'b0}}, byteOut});
  assign busDataOe = cmd.drvData;
  assign busRd     = polHigh ? cmd.rdOn : !cmd.rdOn;
  assign busWr     = polHigh ? cmd.wrOn : !cmd.wrOn;
  assign doneRdata = rdataQ;

  // R10
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN) $onehot0(busSel));

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.selOn && !cmd.rdOn && !cmd.wrOn) |-> ($stable(busAddr) && $stable(busWdata)));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);
endmodule

// File: rtl/ext_strobe_ctrl.sv
`timescale 1ns/1ps
module ext_strobe_ctrl
  import esc_pkg::*;
#(
  parameter int  NUM_SPACES = 4,
  parameter int  ADDR_W     = 16,
  localparam int SP_W       = (NUM_SPACES > 1) ? $clog2(NUM_SPACES) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWe,
  input  logic [SP_W-1:0]       cfgSpace,
  input  logic [13:0]           cfgData,
  input  logic                  reqValid,
  input  logic [SP_W-1:0]       reqSpace,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic                  reqWrite,
  input  logic [15:0]           reqWdata,
  output logic                  busy,
  output logic                  doneValid,
  output logic [15:0]           doneRdata,
  output logic [ADDR_W-1:0]     busAddr,
  output logic [NUM_SPACES-1:0] busSel,
  output logic                  busRd,
  output logic                  busWr,
  output logic [15:0]           busWdata,
  output logic                  busDataOe,
  input  logic [15:0]           busRdData,
  input  logic                  busAck
);
  spaceCfg_t reqCfg;
  dpCmd_t    cmd;
  logic      polHigh, busWide;

  esc_cfg_bank #(.NUM_SPACES(NUM_SPACES), .SP_W(SP_W)) u_cfg (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSpace(cfgSpace),
    .cfgData(spaceCfg_t'(cfgData)), .rdSpace(reqSpace), .rdCfg(reqCfg)
  );

  esc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqCfg(reqCfg), .busAck(busAck), .cmd(cmd), .busy(busy),
    .polHigh(polHigh), .busWide(busWide)
  );

  esc_datapath #(.NUM_SPACES(NUM_SPACES), .ADDR_W(ADDR_W), .SP_W(SP_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .polHigh(polHigh), .busWide(busWide),
    .reqSpace(reqSpace), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .busRdData(busRdData), .busAddr(busAddr), .busSel(busSel),
    .busRd(busRd), .busWr(busWr), .busWdata(busWdata), .busDataOe(busDataOe),
    .doneValid(doneValid), .doneRdata(doneRdata)
  );
endmodule

// File: tb/tb_ext_strobe_ctrl.sv
`timescale 1ns/1ps
module tb_ext_strobe_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSpace = '0;
  logic [13:0] cfgData = '0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqSpace = '0;
  logic [15:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqWdata = '0;
  logic        busAck = 1'b0;
  logic        busy, doneValid, busRd, busWr, busDataOe;
  logic [15:0] doneRdata, busAddr, busWdata, busRdData;
  logic [3:0]  busSel;

  int total = 0, bad = 0;
  bit finished = 0;

  ext_strobe_ctrl dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSpace(cfgSpace), .cfgData(cfgData),
    .reqValid(reqValid), .reqSpace(reqSpace), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .reqWdata(reqWdata), .busy(busy), .doneValid(doneValid), .doneRdata(doneRdata),
    .busAddr(busAddr), .busSel(busSel), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busDataOe(busDataOe), .busRdData(busRdData), .busAck(busAck)
  );

  always #4 clk = ~clk;

  // Memory model: data depends on the address so byte order shows.
  assign busRdData = {busAddr[7:0] ^ 8'h5A, busAddr[7:0] ^ 8'hC3};

  // Observations from one access.
  int nRd, nWr, nPulses, nHold, nDone, latency;
  logic [15:0] addrAt [2];
  logic [15:0] dataAt [2];
  logic [15:0] rdata;
  bit badSel, busyFirst, busyAtDone;

  function automatic logic [15:0] expRd(logic [15:0] a, bit wide);
    logic [15:0] b = a + 16'd1;
    return wide ? {a[7:0] ^ 8'h5A, a[7:0] ^ 8'hC3} : {b[7:0] ^ 8'hC3, a[7:0] ^ 8'hC3};
  endfunction

  function automatic logic [13:0] mkCfg(bit wide, bit pol, bit hold, int div, bit ack, int wrW, int rdW);
    return {wide, pol, hold, 2'(div), ack, 4'(wrW), 4'(rdW)};
  endfunction

  task automatic chk(string what, longint act, longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic setCfg(int sp, logic [13:0] v);
    @(negedge clk);
    cfgWe = 1'b1; cfgSpace = 2'(sp); cfgData = v;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic runAcc(int sp, logic [15:0] addr, bit wr, logic [15:0] wd,
                        bit pol, int ackAfter, bit intrude);
    bit prevAct = 0;
    logic [15:0] prevAddr = '0;
    nRd = 0; nWr = 0; nPulses = 0; nHold = 0; nDone = 0; latency = 0;
    addrAt[0] = '0; addrAt[1] = '0; dataAt[0] = '0; dataAt[1] = '0;
    rdata = '0; badSel = 0; busyFirst = 0; busyAtDone = 1;
    @(negedge clk);
    reqValid = 1'b1; reqSpace = 2'(sp); reqAddr = addr; reqWrite = wr; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    for (int c = 1; c < 400; c++) begin
      bit rdA, wrA, act;
      rdA = (busRd == pol); wrA = (busWr == pol); act = rdA || wrA;
      if (c == 1) busyFirst = busy;
      if (rdA) nRd++;
      if (wrA) nWr++;
      if (act && (!prevAct || busAddr != prevAddr)) begin
        if (nPulses < 2) begin addrAt[nPulses] = busAddr; dataAt[nPulses] = busWdata; end
        nPulses++;
      end
      if (!act && busSel != 4'b0) nHold++;
      if (busSel != 4'b0 && busSel != (4'b1 << sp)) badSel = 1;
      if (ackAfter > 0 && (nRd + nWr) == ackAfter) busAck = 1'b1;
      if (intrude && c == 2) begin reqValid = 1'b1; reqSpace = 2'd3; reqWrite = 1'b1; end
      if (intrude && c == 3) reqValid = 1'b0;
      if (doneValid) begin
        nDone++;
        if (nDone == 1) begin latency = c; rdata = doneRdata; busyAtDone = busy; end
      end
      if (nDone > 0 && c >= latency + 3) break;
      prevAct = act; prevAddr = busAddr;
      @(negedge clk);
    end
    busAck = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 busRd idle", busRd, 1);
    chk("R1 busWr idle", busWr, 1);
    chk("R1 busSel idle", busSel, 0);
    chk("R1 busDataOe idle", busDataOe, 0);
    chk("R1 busy idle", busy, 0);
    chk("R1 doneValid idle", doneValid, 0);
    runAcc(0, 16'h0040, 0, '0, 0, 0, 0);
    chk("R1 default 8-bit pulses", nPulses, 2);
    chk("R1 default read width", nRd, 2);
    chk("R1 default latency", latency, 3);
    chk("R1 default read data", rdata, expRd(16'h0040, 0));
  endtask

  task automatic testWaits();
    setCfg(1, mkCfg(1, 0, 0, 0, 0, 5, 3));
    runAcc(1, 16'h1234, 0, '0, 0, 0, 0);
    chk("R2 read width", nRd, 4);
    chk("R2 read latency", latency, 5);
    chk("R9 single phase read", nPulses, 1);
    chk("R9 full word read", rdata, expRd(16'h1234, 1));
    chk("R10 select read", badSel, 0);
    runAcc(1, 16'h4321, 1, 16'hA55A, 0, 0, 0);
    chk("R3 write width", nWr, 6);
    chk("R3 no read strobe", nRd, 0);
    chk("R3 write data", dataAt[0], 16'hA55A);
    chk("R3 write address", addrAt[0], 16'h4321);
    chk("R3 write latency", latency, 7);
    chk("R9 single phase write", nPulses, 1);
    chk("R6 no hold when off", nHold, 0);
  endtask

  task automatic testDivide();
    setCfg(2, mkCfg(1, 0, 0, 2, 0, 0, 1));
    runAcc(2, 16'h0800, 0, '0, 0, 0, 0);
    chk("R4 divided width", nRd, 6);
    chk("R4 divided latency", latency, 7);
  endtask

  task automatic testAck();
    setCfg(1, mkCfg(1, 0, 0, 0, 1, 0, 1));
    runAcc(1, 16'h0010, 0, '0, 0, 5, 0);
    chk("R5 late ack extends", nRd, 5);
    chk("R5 late ack latency", latency, 6);
    setCfg(1, mkCfg(1, 0, 0, 0, 1, 0, 2));
    runAcc(1, 16'h0011, 0, '0, 0, 1, 0);
    chk("R5 early ack keeps count", nRd, 3);
    setCfg(1, mkCfg(1, 0, 0, 0, 0, 0, 2));
    runAcc(1, 16'h0012, 0, '0, 0, 0, 0);
    chk("R5 ack ignored when off", nRd, 3);
  endtask

  task automatic testHold();
    setCfg(3, mkCfg(1, 0, 1, 1, 0, 1, 0));
    runAcc(3, 16'h3000, 1, 16'h1357, 0, 0, 0);
    chk("R6 write width", nWr, 4);
    chk("R6 hold cycles", nHold, 2);
    chk("R6 hold latency", latency, 7);
    runAcc(3, 16'h3002, 0, '0, 0, 0, 0);
    chk("R6 no hold on read", nHold, 0);
    chk("R6 read latency", latency, 3);
  endtask

  task automatic testPolarity();
    setCfg(2, mkCfg(1, 1, 0, 0, 0, 0, 1));
    runAcc(2, 16'h0900, 0, '0, 1, 0, 0);
    chk("R7 active-high width", nRd, 2);
    chk("R7 active-high latency", latency, 3);
    chk("R7 idle rd level", busRd, 0);
    chk("R7 idle wr level", busWr, 0);
  endtask

  task automatic testByteBus();
    setCfg(0, mkCfg(0, 0, 0, 0, 0, 2, 1));
    runAcc(0, 16'h0101, 1, 16'hBEEF, 0, 0, 0);
    chk("R8 two phases", nPulses, 2);
    chk("R8 first address", addrAt[0], 16'h0101);
    chk("R8 second address", addrAt[1], 16'h0102);
    chk("R8 low byte first", dataAt[0], 16'h00EF);
    chk("R8 high byte second", dataAt[1], 16'h00BE);
    chk("R8 write width", nWr, 6);
    chk("R8 done after second", latency, 7);
    runAcc(0, 16'h20FF, 0, '0, 0, 0, 0);
    chk("R8 read width", nRd, 4);
    chk("R8 read address carry", addrAt[1], 16'h2100);
    chk("R8 read assembly", rdata, expRd(16'h20FF, 0));
    chk("R8 read latency", latency, 5);
  endtask

  task automatic testBusy();
    setCfg(1, mkCfg(1, 0, 0, 0, 0, 0, 5));
    runAcc(1, 16'h0500, 0, '0, 0, 0, 1);
    chk("R11 busy during", busyFirst, 1);
    chk("R11 idle at done", busyAtDone, 0);
    chk("R11 single done", nDone, 1);
    chk("R11 intruder ignored width", nRd, 6);
    chk("R11 no write strobe", nWr, 0);
    chk("R10 intruder never selected", badSel, 0);
    chk("R11 read word", rdata, expRd(16'h0500, 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWaits();
    testDivide();
    testAck();
    testHold();
    testPolarity();
    testByteBus();
    testBusy();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule